// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control decoder of a single-cycle processor that implements a small load/store instruction subset. It is purely combinational. It reads the 6-bit major opcode and the 6-bit function field of the current instruction. From these it drives the datapath steering signals: the destination-register select, the second ALU operand select, the writeback source select, the register-file write enable, the memory read and write strobes, and the branch qualifier. It also drives a 3-bit operation select for the ALU.

Decoding happens in two levels. A main decoder turns the opcode into the steering signals and a 2-bit ALU class. An ALU-control stage then combines that class with the function field. The function field is looked at only when the class marks an arithmetic instruction. Opcodes that are not recognised produce an output that writes nothing. Function codes that are not recognised fall back to an add and raise a flag.

Top module: `insn_ctl_decode`

## Requirements
- R1: Opcode 0 (register format) drives reg_dst=1, reg_wr=1, and alu_src, mem_to_reg, mem_rd, mem_wr and branch all 0.
- R2: Opcode 35 (load) drives alu_src=1, mem_to_reg=1, reg_wr=1, mem_rd=1, and reg_dst, mem_wr and branch all 0.
- R3: Opcode 43 (store) drives alu_src=1 and mem_wr=1. All other control outputs are 0, including reg_dst and mem_to_reg, which no step reads.
- R4: Opcode 4 (branch on equal) drives branch=1 with every other control output 0.
- R5: Any other opcode drives every control output to 0. The ALU select is then 010 and the illegal flag is 0. mem_rd and mem_wr are never both 1.
- R6: For load, store and unrecognised opcodes the ALU select is 010 (add). For branch it is 110 (subtract). In both cases the function field has no effect.
- R7: Under opcode 0, function bits [3:0] select the ALU operation as follows: 0000 gives 010 (add), 0010 gives 110 (subtract), 0100 gives 000 (AND), 0101 gives 001 (OR), and 1010 gives 111 (set on less than).
- R8: Function bits [5:4] never affect any output.
- R9: Under opcode 0, any other value of function bits [3:0] gives ALU select 010 and funct_bad=1. funct_bad is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Major opcode of the instruction |
| funct_i | input | 6 | Function field of the instruction |
| reg_dst_o | output | 1 | Destination register taken from the third register field |
| alu_src_o | output | 1 | Second ALU operand is the sign-extended immediate |
| mem_to_reg_o | output | 1 | Writeback data comes from memory |
| reg_wr_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| branch_o | output | 1 | Branch qualifier, combined with the ALU zero flag by the datapath |
| alu_op_o | output | 3 | ALU operation select |
| funct_bad_o | output | 1 | Unrecognised function code under a register-format opcode |

## Verification
The immediate assertions assume that both inputs are settled, known values. They check relations between the outputs, such as exclusive memory strobes, the paths implied by load and store, subtraction on branch, and add on a bad function code, so they hold for any input combination. The stimulus drives only 2-state values from the bench, changing them at the falling edge. It mixes the four decoded opcodes with random other opcodes, and a full sweep of all 64 function codes covers both the recognised and unrecognised function values.

// File: rtl/insn_ctl_pkg.sv
package insn_ctl_pkg;
  localparam int OPC_W     = 6;
  localparam int FN_W      = 6;
  localparam int FN_SEL_W  = 4;
  localparam int ALU_SEL_W = 3;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;

  localparam logic [ALU_SEL_W-1:0] ALU_AND = 3'b000;
  localparam logic [ALU_SEL_W-1:0] ALU_OR  = 3'b001;
  localparam logic [ALU_SEL_W-1:0] ALU_ADD = 3'b010;
  localparam logic [ALU_SEL_W-1:0] ALU_SUB = 3'b110;
  localparam logic [ALU_SEL_W-1:0] ALU_SLT = 3'b111;

  localparam logic [FN_SEL_W-1:0] FN_ADD = 4'b0000;
  localparam logic [FN_SEL_W-1:0] FN_SUB = 4'b0010;
  localparam logic [FN_SEL_W-1:0] FN_AND = 4'b0100;
  localparam logic [FN_SEL_W-1:0] FN_OR  = 4'b0101;
  localparam logic [FN_SEL_W-1:0] FN_SLT = 4'b1010;

  // ALU class handed from the main decoder to the ALU-control stage
  typedef enum logic [1:0] {
    ACLS_ADD  = 2'b00,
    ACLS_SUB  = 2'b01,
    ACLS_FUNC = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic     reg_dst;
    logic     alu_src;
    logic     mem_to_reg;
    logic     reg_wr;
    logic     mem_rd;
    logic     mem_wr;
    logic     branch;
    alu_cls_e cls;
  } ctl_t;
endpackage

// File: rtl/insn_ctl_main_dec.sv
module insn_ctl_main_dec
  import insn_ctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output ctl_t             ctl_o
);
  always_comb begin
    // safe default: nothing written, nothing read, add class
    ctl_o = '{reg_dst: 1'b0, alu_src: 1'b0, mem_to_reg: 1'b0, reg_wr: 1'b0,
              mem_rd: 1'b0, mem_wr: 1'b0, branch: 1'b0, cls: ACLS_ADD};
    case (opcode_i)
      OPC_RTYPE: begin
        ctl_o.reg_dst = 1'b1;
        ctl_o.reg_wr  = 1'b1;
        ctl_o.cls     = ACLS_FUNC;
      end
      OPC_LOAD: begin
        ctl_o.alu_src    = 1'b1;
        ctl_o.mem_to_reg = 1'b1;
        ctl_o.reg_wr     = 1'b1;
        ctl_o.mem_rd     = 1'b1;
      end
      OPC_STORE: begin
        ctl_o.alu_src = 1'b1;
        ctl_o.mem_wr  = 1'b1;
      end
      OPC_BEQ: begin
        ctl_o.branch = 1'b1;
        ctl_o.cls    = ACLS_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/insn_ctl_alu_dec.sv
module insn_ctl_alu_dec
  import insn_ctl_pkg::*;
(
  input  alu_cls_e             cls_i,
  input  logic [FN_W-1:0]      funct_i,
  output logic [ALU_SEL_W-1:0] alu_op_o,
  output logic                 bad_o
);
  logic [FN_SEL_W-1:0] fn_sel;
  assign fn_sel = funct_i[FN_SEL_W-1:0];

  always_comb begin
    alu_op_o = ALU_ADD;
    bad_o    = 1'b0;
    if (cls_i[1]) begin
      case (fn_sel)
        FN_ADD:  alu_op_o = ALU_ADD;
        FN_SUB:  alu_op_o = ALU_SUB;
        FN_AND:  alu_op_o = ALU_AND;
        FN_OR:   alu_op_o = ALU_OR;
        FN_SLT:  alu_op_o = ALU_SLT;
        default: begin
          alu_op_o = ALU_ADD;
          bad_o    = 1'b1;
        end
      endcase
    end else if (cls_i[0]) begin
      alu_op_o = ALU_SUB;
    end
  end
endmodule

// File: rtl/insn_ctl_decode.sv
module insn_ctl_decode
  import insn_ctl_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output logic       reg_dst_o,
  output logic       alu_src_o,
  output logic       mem_to_reg_o,
  output logic       reg_wr_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       branch_o,
  output logic [2:0] alu_op_o,
  output logic       funct_bad_o
);
  ctl_t ctl;

  insn_ctl_main_dec u_main (
    .opcode_i (opcode_i),
    .ctl_o    (ctl)
  );

  insn_ctl_alu_dec u_alu (
    .cls_i    (ctl.cls),
    .funct_i  (funct_i),
    .alu_op_o (alu_op_o),
    .bad_o    (funct_bad_o)
  );

  assign reg_dst_o    = ctl.reg_dst;
  assign alu_src_o    = ctl.alu_src;
  assign mem_to_reg_o = ctl.mem_to_reg;
  assign reg_wr_o     = ctl.reg_wr;
  assign mem_rd_o     = ctl.mem_rd;
  assign mem_wr_o     = ctl.mem_wr;
  assign branch_o     = ctl.branch;
endmodule

// File: rtl/insn_ctl_decode_chk.sv
module insn_ctl_decode_chk (
  input logic [5:0] opcode_i,
  input logic       reg_dst_o,
  input logic       alu_src_o,
  input logic       mem_to_reg_o,
  input logic       reg_wr_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       branch_o,
  input logic [2:0] alu_op_o,
  input logic       funct_bad_o
);
  logic known_opc;
  assign known_opc = (opcode_i == 6'd0) || (opcode_i == 6'd4) ||
                     (opcode_i == 6'd35) || (opcode_i == 6'd43);

  always_comb begin
    a_r5_strobes_exclusive: assert (!(mem_rd_o && mem_wr_o))
      else $error("R5: memory read and write strobes both set");
    a_r2_load_path: assert (!mem_rd_o || (alu_src_o && mem_to_reg_o && reg_wr_o && !reg_dst_o))
      else $error("R2: load strobe without matching datapath steering");
    a_r3_store_quiet: assert (!mem_wr_o || (!reg_wr_o && !reg_dst_o && !mem_to_reg_o && alu_src_o))
      else $error("R3: store strobe with register path active");
    a_r4_branch_subtracts: assert (!branch_o || (alu_op_o == 3'b110 && !reg_wr_o && !alu_src_o))
      else $error("R4: branch without subtract or with a write");
    a_r9_bad_falls_to_add: assert (!funct_bad_o || (alu_op_o == 3'b010 && reg_dst_o))
      else $error("R9: bad function flag outside register format or not add");
    a_r5_unknown_no_write: assert (known_opc || !(reg_wr_o || mem_wr_o || mem_rd_o || branch_o || funct_bad_o))
      else $error("R5: unrecognised opcode produced an active control");
  end
endmodule

bind insn_ctl_decode insn_ctl_decode_chk u_chk (
  .opcode_i     (opcode_i),
  .reg_dst_o    (reg_dst_o),
  .alu_src_o    (alu_src_o),
  .mem_to_reg_o (mem_to_reg_o),
  .reg_wr_o     (reg_wr_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .branch_o     (branch_o),
  .alu_op_o     (alu_op_o),
  .funct_bad_o  (funct_bad_o)
);

// File: tb/insn_ctl_decode_tb_top.sv
module insn_ctl_decode_tb_top;
  logic clk;
  logic rst_n;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, fbad;
  logic [2:0] alu_op;
  int n_checks;
  int n_fail;
  bit done;

  insn_ctl_decode dut_i (
    .opcode_i     (opcode),
    .funct_i      (funct),
    .reg_dst_o    (reg_dst),
    .alu_src_o    (alu_src),
    .mem_to_reg_o (mem_to_reg),
    .reg_wr_o     (reg_wr),
    .mem_rd_o     (mem_rd),
    .mem_wr_o     (mem_wr),
    .branch_o     (branch),
    .alu_op_o     (alu_op),
    .funct_bad_o  (fbad)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // expected vector: {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, alu_op[2:0], bad}
  function automatic logic [10:0] model(input logic [5:0] op, input logic [5:0] fn);
    logic [6:0] c;
    logic [2:0] a;
    logic b;
    c = 7'b0; a = 3'b010; b = 1'b0;
    case (op)
      6'd0: begin
        c = 7'b1001000;
        case (fn[3:0])
          4'b0000: a = 3'b010;
          4'b0010: a = 3'b110;
          4'b0100: a = 3'b000;
          4'b0101: a = 3'b001;
          4'b1010: a = 3'b111;
          default: begin a = 3'b010; b = 1'b1; end
        endcase
      end
      6'd35: c = 7'b0111100;
      6'd43: c = 7'b0100010;
      6'd4:  begin c = 7'b0000001; a = 3'b110; end
      default: ;
    endcase
    return {c, a, b};
  endfunction

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      6'd0:  return "R1/R7/R9";
      6'd35: return "R2/R6";
      6'd43: return "R3/R6";
      6'd4:  return "R4/R6";
      default: return "R5/R6";
    endcase
  endfunction

  task automatic apply_chk(input logic [5:0] op, input logic [5:0] fn, input string tag);
    logic [10:0] act;
    logic [10:0] exp;
    @(negedge clk);
    opcode = op;
    funct  = fn;
    #1;
    act = {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, alu_op, fbad};
    exp = model(op, fn);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d fn=%b actual=%b expected=%b", tag, op, fn, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [5:0] op;
    logic [5:0] fn;
    int unsigned seed;
    n_checks = 0;
    n_fail = 0;
    done = 1'b0;
    seed = 32'd12345;
    void'($urandom(seed));
    rst_n = 1'b0;
    opcode = 6'd0;
    funct = 6'd0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset-time state: register format, add
    apply_chk(6'd0, 6'd0, "R1");
    // R7 each recognised function code
    apply_chk(6'd0, 6'b100000, "R7");
    apply_chk(6'd0, 6'b100010, "R7");
    apply_chk(6'd0, 6'b100100, "R7");
    apply_chk(6'd0, 6'b100101, "R7");
    apply_chk(6'd0, 6'b101010, "R7");
    // R2 R3 R4 directed, function field nonzero to show it is ignored (R6)
    apply_chk(6'd35, 6'b101010, "R2");
    apply_chk(6'd43, 6'b100100, "R3");
    apply_chk(6'd4, 6'b100101, "R4");
    apply_chk(6'd4, 6'b111111, "R6");
    // R5 jump-style and edge opcodes
    apply_chk(6'd2, 6'd0, "R5");
    apply_chk(6'd63, 6'b101010, "R5");
    apply_chk(6'd36, 6'b111111, "R5");
    // R8 and R9 full sweep of the function field under register format
    for (int i = 0; i < 64; i++) apply_chk(6'd0, 6'(i), "R8/R9");
    // R6 function sweep on load and store
    for (int i = 0; i < 64; i++) apply_chk((i % 2 == 0) ? 6'd35 : 6'd43, 6'(i), "R6");
    // random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 4))
        0: op = 6'd0;
        1: op = 6'd4;
        2: op = 6'd35;
        3: op = 6'd43;
        default: op = 6'($urandom_range(0, 63));
      endcase
      fn = 6'($urandom_range(0, 63));
      apply_chk(op, fn, tag_of(op));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule